// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block is the receive-side DMA engine of a network interface. It walks a list of 32-byte descriptors in system memory and stores each incoming frame into the buffers that those descriptors point to. Each descriptor carries an ownership flag that says whether the engine or the host owns it. The engine writes data only into descriptors it owns, and it hands each one back to the host by rewriting the descriptor's first word with status.

A frame arrives as a byte stream with start and end markers and a ready handshake. The engine fetches the descriptor when a frame begins and packs the bytes into 32-bit words. It fills buffer 1 and then buffer 2, and moves on to the next descriptor when both are full. The next descriptor is found in one of three ways: the list base (end of ring), a pointer held in the descriptor (chained), or the following 32-byte slot. When a frame closes, the engine pulses a done output. It raises an interrupt request in the same cycle unless the closing descriptor asks to suppress it. A host-owned descriptor at the start of a frame makes the engine drop the frame and pulse a buffer-unavailable flag.

Top module: `rx_desc_walker`

## Requirements
- R1: Frame data is written only into a descriptor whose word 0 bit 31 was 1 when it was fetched. The engine returns every descriptor it fills by writing word 0 with bit 31 = 0.
- R2: If the descriptor at the current pointer has word 0 bit 31 = 0 when a frame starts, the whole frame is consumed and discarded with no memory write, `bufUnavail` pulses once, and the next frame tries the same descriptor again.
- R3: Frame bytes are stored little-endian (first byte in bits 7:0) as whole 32-bit words at consecutive addresses from the buffer start. The final word is zero-padded, and no word past it is written.
- R4: The buffer sizes are word 1 bits 12:0 (buffer 1, at address word 2) and word 1 bits 28:16 (buffer 2, at address word 3), in bytes, with the two low bits ignored. A size of 0 skips that buffer.
- R5: When word 1 bit 14 is set, word 3 is the next-descriptor pointer and the buffer 2 size is ignored.
- R6: When word 1 bit 15 is set, the next descriptor is at `baseAddr`. This takes precedence over bit 14.
- R7: With neither bit 14 nor bit 15 set, the next descriptor is at the current descriptor address plus 32.
- R8: A frame that overflows a descriptor continues in the next owned descriptor. Returned word 0 has bit 9 set where the frame's first byte lies and bit 8 set in the descriptor that closes the frame. The frame byte count is written in bits 29:16 of the closing descriptor only, and is 0 elsewhere.
- R9: If a descriptor's buffers fill before the frame ends and the next descriptor has bit 31 = 0, the current descriptor closes with bits 8 and 14 set and the stored byte count, and the rest of the frame is discarded. A frame that ends exactly on the last buffer word closes normally without bit 14.
- R10: `frameDone` is a one-cycle pulse for each closed frame. `irq` pulses with it unless word 1 bit 31 of the closing descriptor is set.
- R11: After reset the engine makes no memory request and does not accept bytes, and it fetches its first descriptor from `baseAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | AW | Byte address of the first descriptor of the list |
| memReq | output | 1 | Memory access request, always granted |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the access (word aligned) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| inValid | input | 1 | Byte on `inData` is valid |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inReady | output | 1 | Byte is taken on this edge when `inValid` is high |
| frameDone | output | 1 | Pulse: a frame was closed into a descriptor |
| irq | output | 1 | Pulse: receive-complete interrupt request |
| bufUnavail | output | 1 | Pulse: frame dropped, descriptor owned by host |

## Verification
The hardest situation to reach is a truncation: a frame that fills a descriptor's buffers while the descriptor after it is still held by the host. The bench prepares memory so that a small single-buffer descriptor is followed by a host-owned slot, then sends a frame longer than that buffer. It checks the error and closing bits, the stored byte count, the untouched words after the buffer, and the drop of the following frame at the host-owned slot. The chained and ring-end walks use the same approach. Both bits are set with a decoy pointer, and the next frame must land at the base of the list. A fitted frame sent afterwards shows that an exact fill does not truncate.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  // word 0 status bit positions (decoded by host software)
  localparam int OWN_BIT   = 31;
  localparam int LEN_LSB   = 16;
  localparam int ERR_BIT   = 14;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  // word 1 control bit positions
  localparam int SUPP_BIT  = 31;
  localparam int RING_BIT  = 15;
  localparam int CHAIN_BIT = 14;
  localparam int SZ1_LSB   = 0;
  localparam int SZ2_LSB   = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EVAL, S_RECV, S_NCHK,
    S_NCAP, S_WBMID, S_CLOSE, S_DROP, S_TRUNC
  } walkState_t;

  typedef struct packed {
    logic       frameClear;
    logic       rdReq;
    logic [1:0] rdWord;
    logic       capWord;
    logic [1:0] capIdx;
    logic       loadBuf;
    logic       recvMode;
    logic       rdNext;
    logic       wrStatus;
    logic       statusLast;
    logic       statusErr;
    logic       advance;
  } walkCmd_t;
endpackage

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
  import rxdw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inSof,
  input  logic     inEof,
  output logic     inReady,
  input  logic     descOwn,
  input  logic     capZero,
  input  logic     wordOut,
  input  logic     lastSlot,
  input  logic     rdOwn,
  input  logic     suppress,
  output walkCmd_t cmd,
  output logic     frameDone,
  output logic     irq,
  output logic     bufUnavail
);
  walkState_t state, nxt;
  logic [2:0] fetchCnt, cntNext;
  logic       deFlag;

  always_comb begin
    cmd     = '0;
    nxt     = state;
    inReady = 1'b0;
    cntNext = fetchCnt;
    case (state)
      S_IDLE: begin
        if (inValid && inSof) begin
          cmd.frameClear = 1'b1;
          cntNext        = 3'd0;
          nxt            = S_FETCH;
        end
      end
      S_FETCH: begin
        cmd.rdReq   = (fetchCnt < 3'd4);
        cmd.rdWord  = fetchCnt[1:0];
        cmd.capWord = (fetchCnt != 3'd0);
        cmd.capIdx  = fetchCnt[1:0] - 2'd1;
        cntNext     = fetchCnt + 3'd1;
        if (fetchCnt == 3'd4) nxt = S_EVAL;
      end
      S_EVAL: begin
        cmd.loadBuf = 1'b1;
        if (!descOwn)     nxt = S_DROP;
        else if (capZero) nxt = S_NCHK;
        else              nxt = S_RECV;
      end
      S_RECV: begin
        inReady      = 1'b1;
        cmd.recvMode = 1'b1;
        if (inValid && inEof)         nxt = S_CLOSE;
        else if (wordOut && lastSlot) nxt = S_NCHK;
      end
      S_NCHK: begin
        cmd.rdNext = 1'b1;
        nxt        = S_NCAP;
      end
      S_NCAP: nxt = rdOwn ? S_WBMID : S_CLOSE;
      S_WBMID: begin
        cmd.wrStatus = 1'b1;
        cmd.advance  = 1'b1;
        cntNext      = 3'd0;
        nxt          = S_FETCH;
      end
      S_CLOSE: begin
        cmd.wrStatus   = 1'b1;
        cmd.statusLast = 1'b1;
        cmd.statusErr  = deFlag;
        cmd.advance    = 1'b1;
        nxt            = deFlag ? S_TRUNC : S_IDLE;
      end
      S_DROP, S_TRUNC: begin
        inReady = 1'b1;
        if (inValid && inEof) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      fetchCnt <= 3'd0;
      deFlag   <= 1'b0;
    end else begin
      state    <= nxt;
      fetchCnt <= cntNext;
      if (cmd.frameClear)              deFlag <= 1'b0;
      else if (state == S_NCAP && !rdOwn) deFlag <= 1'b1;
    end
  end

  assign frameDone  = (state == S_CLOSE);
  assign irq        = frameDone && !suppress;
  assign bufUnavail = (state == S_EVAL) && !descOwn;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
endmodule

// File: rtl/rxdw_datapath.sv
module rxdw_datapath
  import rxdw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 14,
  parameter int SIZE_W     = 13,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] baseAddr,
  input  walkCmd_t      cmd,
  input  logic          inValid,
  input  logic          inReady,
  input  logic [7:0]    inData,
  input  logic          inEof,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          descOwn,
  output logic          capZero,
  output logic          wordOut,
  output logic          lastSlot,
  output logic          rdOwn,
  output logic          suppress
);
  localparam int WW = SIZE_W - 2;

  logic          ptrValid, ringEnd, chained, buf2Pend, descHasFirst;
  logic [AW-1:0] curDesc, buf1Addr, w3Addr, bufAddr, curPtr, nextAddr;
  logic [WW-1:0] size1W, size2W, bufLeft;
  logic [31:0]   packReg, wrData, statusWord;
  logic [1:0]    packCnt;
  logic [LEN_W-1:0] frameLen;
  logic          acc;

  assign acc      = cmd.recvMode && inValid && inReady;
  assign wordOut  = acc && (packCnt == 2'd3 || inEof);
  assign lastSlot = (bufLeft == WW'(1)) && !buf2Pend;
  assign capZero  = (size1W == '0) && (chained || size2W == '0);
  assign rdOwn    = memRdata[OWN_BIT];

  assign curPtr   = ptrValid ? curDesc : baseAddr;
  assign nextAddr = ringEnd ? baseAddr : (chained ? w3Addr : curPtr + AW'(DESC_BYTES));

  always_comb begin
    wrData = packReg;
    wrData[{packCnt, 3'b000} +: 8] = inData;
  end

  always_comb begin
    statusWord = '0;
    statusWord[LEN_LSB +: LEN_W] = cmd.statusLast ? frameLen : '0;
    statusWord[ERR_BIT]   = cmd.statusErr;
    statusWord[FIRST_BIT] = descHasFirst;
    statusWord[LAST_BIT]  = cmd.statusLast;
  end

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = curPtr;
    memWdata = wrData;
    if (wordOut) begin
      memReq  = 1'b1;
      memWe   = 1'b1;
      memAddr = bufAddr;
    end else if (cmd.wrStatus) begin
      memReq   = 1'b1;
      memWe    = 1'b1;
      memWdata = statusWord;
    end else if (cmd.rdReq) begin
      memReq  = 1'b1;
      memAddr = curPtr + AW'({cmd.rdWord, 2'b00});
    end else if (cmd.rdNext) begin
      memReq  = 1'b1;
      memAddr = nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrValid <= 1'b0; curDesc <= '0; descOwn <= 1'b0; suppress <= 1'b0;
      ringEnd <= 1'b0; chained <= 1'b0; size1W <= '0; size2W <= '0;
      buf1Addr <= '0; w3Addr <= '0; bufAddr <= '0; bufLeft <= '0;
      buf2Pend <= 1'b0; packReg <= '0; packCnt <= 2'd0; frameLen <= '0;
      descHasFirst <= 1'b0;
    end else begin
      if (cmd.capWord) begin
        case (cmd.capIdx)
          2'd0: descOwn <= memRdata[OWN_BIT];
          2'd1: begin
            suppress <= memRdata[SUPP_BIT];
            ringEnd  <= memRdata[RING_BIT];
            chained  <= memRdata[CHAIN_BIT];
            size1W   <= memRdata[SZ1_LSB + 2 +: WW];
            size2W   <= memRdata[SZ2_LSB + 2 +: WW];
          end
          2'd2: buf1Addr <= memRdata[AW-1:0];
          default: w3Addr <= memRdata[AW-1:0];
        endcase
      end
      // buffer pointer: buffer 1, then buffer 2 unless chained
      if (cmd.loadBuf) begin
        if (size1W != '0) begin
          bufAddr  <= buf1Addr;
          bufLeft  <= size1W;
          buf2Pend <= !chained && (size2W != '0);
        end else if (!chained && size2W != '0) begin
          bufAddr  <= w3Addr;
          bufLeft  <= size2W;
          buf2Pend <= 1'b0;
        end else begin
          bufLeft  <= '0;
          buf2Pend <= 1'b0;
        end
      end else if (wordOut) begin
        if (bufLeft == WW'(1) && buf2Pend) begin
          bufAddr  <= w3Addr;
          bufLeft  <= size2W;
          buf2Pend <= 1'b0;
        end else begin
          bufAddr <= bufAddr + AW'(4);
          bufLeft <= bufLeft - WW'(1);
        end
      end
      if (acc) begin
        if (wordOut) begin
          packReg <= '0;
          packCnt <= 2'd0;
        end else begin
          packReg[{packCnt, 3'b000} +: 8] <= inData;
          packCnt <= packCnt + 2'd1;
        end
      end
      if (cmd.frameClear) frameLen <= '0;
      else if (acc)       frameLen <= frameLen + LEN_W'(1);
      if (cmd.frameClear || cmd.advance)  descHasFirst <= 1'b0;
      else if (acc && frameLen == '0)     descHasFirst <= 1'b1;
      if (cmd.advance) begin
        curDesc  <= nextAddr;
        ptrValid <= 1'b1;
      end
    end
  end

  assert_owned_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    wordOut |-> descOwn);
  assert_pack_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordOut |=> packCnt == 2'd0);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    wordOut |-> bufLeft != '0);
  assert_len_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> frameLen == $past(frameLen) + LEN_W'(1));
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rxdw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 14,
  parameter int SIZE_W     = 13,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] baseAddr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inSof,
  input  logic          inEof,
  output logic          inReady,
  output logic          frameDone,
  output logic          irq,
  output logic          bufUnavail
);
  walkCmd_t cmd;
  logic descOwn, capZero, wordOut, lastSlot, rdOwn, suppress;

  rxdw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inReady(inReady), .descOwn(descOwn), .capZero(capZero), .wordOut(wordOut),
    .lastSlot(lastSlot), .rdOwn(rdOwn), .suppress(suppress), .cmd(cmd),
    .frameDone(frameDone), .irq(irq), .bufUnavail(bufUnavail)
  );

  rxdw_datapath #(.AW(AW), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .DESC_BYTES(DESC_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .cmd(cmd), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inEof(inEof), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .descOwn(descOwn), .capZero(capZero), .wordOut(wordOut), .lastSlot(lastSlot),
    .rdOwn(rdOwn), .suppress(suppress)
  );

  assert_drop_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavail |=> !memReq);
endmodule

// File: tb/tb_rx_desc_walker.sv
module tb_rx_desc_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] baseAddr = 32'h100;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, frameDone, irq, bufUnavail;

  int total = 0, fails = 0;
  int doneCnt = 0, irqCnt = 0, unavCnt = 0;
  logic [31:0] mem [0:1023];
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  always #4 clk = ~clk;

  rx_desc_walker dut (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .inValid(inValid),
    .inData(inData), .inSof(inSof), .inEof(inEof), .inReady(inReady),
    .frameDone(frameDone), .irq(irq), .bufUnavail(bufUnavail)
  );

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else       memRdata <= mem[memAddr[11:2]];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      doneCnt += int'(frameDone);
      irqCnt  += int'(irq);
      unavCnt += int'(bufUnavail);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int addr);
    return mem[addr >> 2];
  endfunction

  task automatic setDesc(input int a, input logic [31:0] w0, w1, w2, w3);
    mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1; mem[(a >> 2) + 2] = w2; mem[(a >> 2) + 3] = w3;
  endtask

  function automatic logic [31:0] expWord(input logic [7:0] seed, input int n, input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (k * 4 + j < n) w[8*j +: 8] = seed + 8'(k * 4 + j);
    return w;
  endfunction

  task automatic pushByte(input logic [7:0] b, input logic sof, input logic eof);
    logic taken = 1'b0;
    inValid = 1'b1; inData = b; inSof = sof; inEof = eof;
    while (!taken) begin
      #1;
      if (inReady) taken = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic sendFrame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) pushByte(seed + 8'(i), i == 0, i == n - 1);
    repeat (10) @(negedge clk);
  endtask

  // R11: idle after reset
  task automatic testReset();
    chk("R11 memReq idle", {31'b0, memReq}, 32'd0);
    chk("R11 inReady low", {31'b0, inReady}, 32'd0);
    chk("R11 no done/irq/unavail", {29'b0, frameDone, irq, bufUnavail}, 32'd0);
  endtask

  // R1 R3 R11: one short frame into the base descriptor
  task automatic testSingle();
    sendFrame(10, 8'h10);
    for (int k = 0; k < 3; k++) chk("R3 data word", rd(32'h400 + 4*k), expWord(8'h10, 10, k));
    chk("R3 no write past last word", rd(32'h40C), SENT);
    chk("R1 R11 base status", rd(32'h100), 32'h000A0300);
    chk("R10 done count", doneCnt, 1);
    chk("R10 irq count", irqCnt, 1);
  endtask

  // R4 R7 R10: sequential next, buffer 1 size 0, irq suppressed
  task automatic testSkipSeq();
    sendFrame(6, 8'h20);
    chk("R4 R7 buf2 word0", rd(32'h480), expWord(8'h20, 6, 0));
    chk("R4 buf2 word1", rd(32'h484), expWord(8'h20, 6, 1));
    chk("R7 status at +32", rd(32'h120), 32'h00060300);
    chk("R10 done count", doneCnt, 2);
    chk("R10 irq suppressed", irqCnt, 1);
  endtask

  // R2 R5 R8: host-owned drop, retry, chained spill
  task automatic testDropChain();
    sendFrame(8, 8'h30);
    chk("R2 no data write", rd(32'h500), SENT);
    chk("R2 unavail pulse", unavCnt, 1);
    chk("R2 no done", doneCnt, 2);
    mem[32'h140 >> 2] = 32'h8000_0000;
    sendFrame(12, 8'h40);
    chk("R2 R8 first buffer w0", rd(32'h500), expWord(8'h40, 12, 0));
    chk("R8 first buffer w1", rd(32'h504), expWord(8'h40, 12, 1));
    chk("R5 buf2 ignored", rd(32'h508), SENT);
    chk("R8 first desc status", rd(32'h140), 32'h00000200);
    chk("R5 R8 chained desc status", rd(32'h200), 32'h000C0100);
    chk("R5 chained data", rd(32'h540), expWord(8'h40, 12, 2));
    chk("R10 done/irq", doneCnt * 16 + irqCnt, 3 * 16 + 2);
  endtask

  // R6: end-of-ring wins over chained
  task automatic testRing();
    mem[32'h100 >> 2] = 32'h8000_0000;
    sendFrame(4, 8'h80);
    chk("R6 back at base data", rd(32'h400), expWord(8'h80, 4, 0));
    chk("R6 base status", rd(32'h100), 32'h00040300);
    chk("R6 chain pointer unused", rd(32'h300), SENT);
  endtask

  // R9: truncation, then exact fit
  task automatic testTrunc();
    setDesc(32'h120, 32'h8000_0000, 32'd8, 32'h600, 32'h680);
    sendFrame(20, 8'hA0);
    chk("R9 stored w0", rd(32'h600), expWord(8'hA0, 20, 0));
    chk("R9 stored w1", rd(32'h604), expWord(8'hA0, 20, 1));
    chk("R9 rest discarded", rd(32'h608), SENT);
    chk("R9 error status", rd(32'h120), 32'h00084300);
    chk("R9 R10 done", doneCnt, 5);
    sendFrame(4, 8'hC0);
    chk("R9 R2 next slot dropped", unavCnt, 2);
    setDesc(32'h140, 32'h8000_0000, 32'd8, 32'h700, 32'h0);
    mem[32'h160 >> 2] = 32'h0;
    sendFrame(8, 8'hD0);
    chk("R9 exact fit data", rd(32'h704), expWord(8'hD0, 8, 1));
    chk("R9 exact fit no error", rd(32'h140), 32'h00080300);
    chk("R10 irq total", irqCnt, 5);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = SENT;
    setDesc(32'h100, 32'h8000_0000, 32'd64, 32'h400, 32'h0);
    setDesc(32'h120, 32'h8000_0000, 32'h8008_0000, 32'h0, 32'h480);
    setDesc(32'h140, 32'h0, 32'h0010_4008, 32'h500, 32'h200);
    setDesc(32'h200, 32'h8000_0000, 32'h0000_C010, 32'h540, 32'h300);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testSkipSeq();
    testDropChain();
    testRing();
    testTrunc();
    summary();
  end
endmodule